// File: doc/BRIEF.md
# Two-Channel Bus Master Arbiter with Configurable Preemption

This block shares one bus-master port between a transmit DMA engine and a receive DMA engine. Each engine raises a request line while it wants the bus and drops it at the end of its transfer. The arbiter answers with one-hot grants. While one engine owns the port, the arbiter may ask it to yield by raising a preempt request. It does so only when a waiting engine is allowed to take over and either the latency timer has expired or the target has disconnected the current burst.

Two configuration bits set which side may preempt the other. The receive priority bit lets receive take the bus from a transmit owner. The transmit priority bit lets transmit take the bus from a receive owner. Both bits may be set, or neither. An owner that reports exactly one dword remaining is never asked to yield, because its transfer is about to end anyway. When both engines ask for the bus from idle, the grant goes to the side that did not hold it last, and the pointer starts at receive after reset.

A fatal-error input shuts the port off. Both grants stay low until the next reset. There is no data path through this block, so every pin is a plain control or status level. The bus protocol and the latency timer's counting live outside the block.

Top module: `dma_bus_arbiter`

## Requirements
- R1: During and after reset, until a request is sampled, tx_gnt, rx_gnt and preempt_req are all 0.
- R2: At most one grant is high at any time. From idle, a lone request is granted on the clock edge after it is sampled.
- R3: When both requests are sampled high while the port is idle, the grant goes to the side not granted most recently. After reset, receive counts as the side to go first.
- R4: A grant stays high while its requester keeps its request high. When the owner drops its request, the grant falls on the next edge. At least one cycle with both grants low separates two owners.
- R5: With rx_pri=1, a transmit owner that is not on its last dword, and rx_req=1, a sampled lat_expired raises preempt_req on the next edge.
- R6: With tx_pri=1, a receive owner that is not on its last dword, and tx_req=1, a sampled lat_expired raises preempt_req on the next edge.
- R7: When the waiting side's priority bit is 0, preempt_req stays 0 whatever the timer or disconnect inputs do.
- R8: While the owner's last-dword input (tx_last_dw for a transmit owner, rx_last_dw for a receive owner) is high, preempt_req is 0 on the following edge. This also cancels a pending preempt request.
- R9: A sampled tgt_disc raises preempt_req under the same conditions as lat_expired.
- R10: Once raised, preempt_req stays high until the owner drops its request, the waiting side drops its request, or R8 applies.
- R11: A sampled fatal_err forces both grants and preempt_req to 0 from the next edge until reset, whatever the requests do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | 1 | Transmit DMA wants the bus |
| rx_req | input | 1 | Receive DMA wants the bus |
| tx_last_dw | input | 1 | Transmit DMA has exactly one dword left |
| rx_last_dw | input | 1 | Receive DMA has exactly one dword left |
| lat_expired | input | 1 | Latency timer expiry |
| tgt_disc | input | 1 | Target disconnected the current burst |
| tx_pri | input | 1 | Transmit may preempt a receive owner |
| rx_pri | input | 1 | Receive may preempt a transmit owner |
| fatal_err | input | 1 | Fatal error; port shut until reset |
| tx_gnt | output | 1 | Bus granted to transmit DMA |
| rx_gnt | output | 1 | Bus granted to receive DMA |
| preempt_req | output | 1 | Current owner is asked to yield |

## Verification
The hardest state to reach is a held preempt request that is later cancelled. This needs an owner, a waiting requester whose priority bit is set, and a timer or disconnect pulse, all at once. After that, the owner must reach its last dword, or the waiter must withdraw, before the owner releases. Directed sequences build each of these situations step by step. Seeded random traffic then runs with sticky requests and short pulses, under each of the four priority settings, and a cycle-level reference model in the bench checks every cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_TX   = 2'd1,
    OWN_RX   = 2'd2
  } owner_e;
endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
  import dma_arb_pkg::*;
(
  input  logic   tx_req,
  input  logic   rx_req,
  input  logic   last_was_tx,
  output owner_e pick
);
  // round-robin choice between the two requesters when the port is idle
  always_comb begin
    if (tx_req && rx_req) pick = last_was_tx ? OWN_RX : OWN_TX;
    else if (rx_req)      pick = OWN_RX;
    else if (tx_req)      pick = OWN_TX;
    else                  pick = OWN_NONE;
  end
endmodule

// File: rtl/dma_arb_preempt.sv
module dma_arb_preempt
  import dma_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   kill,
  input  owner_e owner,
  input  logic   tx_req,
  input  logic   rx_req,
  input  logic   tx_last_dw,
  input  logic   rx_last_dw,
  input  logic   lat_expired,
  input  logic   tgt_disc,
  input  logic   tx_pri,
  input  logic   rx_pri,
  output logic   preempt_req
);
  logic own_req, wait_req, wait_pri, own_last, trigger, pre_d;

  always_comb begin
    own_req  = 1'b0;
    wait_req = 1'b0;
    wait_pri = 1'b0;
    own_last = 1'b0;
    unique case (owner)
      OWN_TX: begin own_req = tx_req; wait_req = rx_req; wait_pri = rx_pri; own_last = tx_last_dw; end
      OWN_RX: begin own_req = rx_req; wait_req = tx_req; wait_pri = tx_pri; own_last = rx_last_dw; end
      default: ;
    endcase
    trigger = lat_expired || tgt_disc || preempt_req;
    pre_d   = !kill && (owner != OWN_NONE) && own_req && wait_req && wait_pri
              && !own_last && trigger;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) preempt_req <= 1'b0;
    else        preempt_req <= pre_d;
  end

  AST_NO_PRE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (owner != OWN_NONE && own_last) |=> !preempt_req); // R8
  AST_NO_PRE_UNPRIV: assert property (@(posedge clk) disable iff (!rst_n)
    (owner != OWN_NONE && !wait_pri) |=> !preempt_req); // R7
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter bit FIRST_RX = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_req,
  input  logic rx_req,
  input  logic tx_last_dw,
  input  logic rx_last_dw,
  input  logic lat_expired,
  input  logic tgt_disc,
  input  logic tx_pri,
  input  logic rx_pri,
  input  logic fatal_err,
  output logic tx_gnt,
  output logic rx_gnt,
  output logic preempt_req
);
  localparam logic LAST_TX_INIT = FIRST_RX;

  owner_e own_q, pick;
  logic   last_tx_q, fatal_q, kill;

  assign kill = fatal_err || fatal_q;

  dma_arb_pick u_pick (
    .tx_req      (tx_req),
    .rx_req      (rx_req),
    .last_was_tx (last_tx_q),
    .pick        (pick)
  );

  dma_arb_preempt u_pre (
    .clk         (clk),
    .rst_n       (rst_n),
    .kill        (kill),
    .owner       (own_q),
    .tx_req      (tx_req),
    .rx_req      (rx_req),
    .tx_last_dw  (tx_last_dw),
    .rx_last_dw  (rx_last_dw),
    .lat_expired (lat_expired),
    .tgt_disc    (tgt_disc),
    .tx_pri      (tx_pri),
    .rx_pri      (rx_pri),
    .preempt_req (preempt_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q     <= OWN_NONE;
      last_tx_q <= LAST_TX_INIT;
      fatal_q   <= 1'b0;
    end else if (kill) begin
      fatal_q <= 1'b1;
      own_q   <= OWN_NONE;
    end else begin
      unique case (own_q)
        OWN_NONE: begin
          own_q <= pick;
          if (pick == OWN_TX) last_tx_q <= 1'b1;
          if (pick == OWN_RX) last_tx_q <= 1'b0;
        end
        OWN_TX: if (!tx_req) own_q <= OWN_NONE;
        OWN_RX: if (!rx_req) own_q <= OWN_NONE;
        default: own_q <= OWN_NONE;
      endcase
    end
  end

  assign tx_gnt = (own_q == OWN_TX);
  assign rx_gnt = (own_q == OWN_RX);

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_gnt && rx_gnt)); // R2
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_gnt && tx_req && !kill) |=> tx_gnt); // R4
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_gnt && rx_req && !kill) |=> rx_gnt); // R4
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_gnt && !tx_req) |=> !rx_gnt); // R4
  AST_FATAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_err |=> (!tx_gnt && !rx_gnt && !preempt_req)); // R11
  AST_PRE_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_req |-> (tx_gnt || rx_gnt)); // R10
endmodule

// File: tb/dma_bus_arbiter_tb.sv
module dma_bus_arbiter_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_req = 0, rx_req = 0, tx_last_dw = 0, rx_last_dw = 0;
  logic lat_expired = 0, tgt_disc = 0, tx_pri = 0, rx_pri = 0, fatal_err = 0;
  logic tx_gnt, rx_gnt, preempt_req;

  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_bus_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .rx_req(rx_req),
    .tx_last_dw(tx_last_dw), .rx_last_dw(rx_last_dw),
    .lat_expired(lat_expired), .tgt_disc(tgt_disc),
    .tx_pri(tx_pri), .rx_pri(rx_pri), .fatal_err(fatal_err),
    .tx_gnt(tx_gnt), .rx_gnt(rx_gnt), .preempt_req(preempt_req)
  );

  // reference model: 0 idle, 1 tx owner, 2 rx owner
  int m_own = 0;
  bit m_last_tx = 1'b1, m_pre = 1'b0, m_fatal = 1'b0;

  function automatic int pick_fn(bit t, bit r, bit last_tx);
    if (t && r) return last_tx ? 2 : 1;
    if (r) return 2;
    if (t) return 1;
    return 0;
  endfunction

  function automatic bit pre_fn(int own, bit pre, bit kill);
    bit oreq, wreq, wpri, olast;
    oreq  = (own == 1) ? tx_req : rx_req;
    wreq  = (own == 1) ? rx_req : tx_req;
    wpri  = (own == 1) ? rx_pri : tx_pri;
    olast = (own == 1) ? tx_last_dw : rx_last_dw;
    return !kill && own != 0 && oreq && wreq && wpri && !olast
           && (lat_expired || tgt_disc || pre);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_own = 0; m_last_tx = 1'b1; m_pre = 1'b0; m_fatal = 1'b0;
    end else begin
      bit kill;
      int nxt;
      kill  = fatal_err || m_fatal;
      m_pre = pre_fn(m_own, m_pre, kill);
      if (kill) begin
        m_fatal = 1'b1; nxt = 0;
      end else if (m_own == 0) begin
        nxt = pick_fn(tx_req, rx_req, m_last_tx);
        if (nxt == 1) m_last_tx = 1'b1;
        if (nxt == 2) m_last_tx = 1'b0;
      end else if (m_own == 1) nxt = tx_req ? 1 : 0;
      else nxt = rx_req ? 2 : 0;
      m_own = nxt;
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // whole-run comparison against the model, sampled mid-cycle
  always @(negedge clk) if (rst_n) begin
    chk("R2", "model tx_gnt", tx_gnt, m_own == 1);
    chk("R2", "model rx_gnt", rx_gnt, m_own == 2);
    chk("R10", "model preempt_req", preempt_req, m_pre);
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {tx_req, rx_req, tx_last_dw, rx_last_dw, lat_expired, tgt_disc, fatal_err} = '0;
    repeat (3) cyc();
    chk("R1", "reset tx_gnt", tx_gnt, 1'b0);
    chk("R1", "reset rx_gnt", rx_gnt, 1'b0);
    chk("R1", "reset preempt", preempt_req, 1'b0);
    rst_n = 1'b1;
    cyc();
    chk("R1", "idle preempt", preempt_req, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    tx_pri = 0; rx_pri = 0;
    do_reset();

    // R3: both from idle after reset -> receive first
    tx_req = 1; rx_req = 1; cyc();
    chk("R3", "rx first", rx_gnt, 1'b1);
    chk("R3", "tx waits", tx_gnt, 1'b0);
    cyc();
    chk("R4", "owner holds", rx_gnt, 1'b1);
    // R7: no priority bits -> no preempt
    lat_expired = 1; tgt_disc = 1; cyc();
    chk("R7", "no preempt without pri", preempt_req, 1'b0);
    tgt_disc = 0;
    // R8: last dword blocks preempt
    tx_pri = 1; rx_last_dw = 1; cyc();
    chk("R8", "last dword blocks", preempt_req, 1'b0);
    // R6: receive owner preempted by transmit
    rx_last_dw = 0; cyc();
    chk("R6", "tx preempts rx owner", preempt_req, 1'b1);
    lat_expired = 0; cyc();
    chk("R10", "preempt held", preempt_req, 1'b1);
    // R8: last dword cancels pending preempt
    rx_last_dw = 1; cyc();
    chk("R8", "last dword cancels", preempt_req, 1'b0);
    rx_last_dw = 0;
    // R4: release, idle gap, then tx
    rx_req = 0; cyc();
    chk("R4", "gap rx low", rx_gnt, 1'b0);
    chk("R4", "gap tx low", tx_gnt, 1'b0);
    cyc();
    chk("R4", "tx after gap", tx_gnt, 1'b1);
    // R9: disconnect triggers preempt for rx with rx_pri
    tx_pri = 0; rx_pri = 1; rx_req = 1; tgt_disc = 1; cyc();
    chk("R9", "disconnect preempts", preempt_req, 1'b1);
    tgt_disc = 0; tx_req = 0; cyc();
    chk("R10", "release clears preempt", preempt_req, 1'b0);
    tx_req = 1; cyc();
    chk("R3", "alternates to rx", rx_gnt, 1'b1);
    // back to tx owner for R5
    rx_req = 0; cyc(); cyc();
    chk("R2", "lone tx granted", tx_gnt, 1'b1);
    rx_req = 1; lat_expired = 1; cyc();
    chk("R5", "rx preempts tx owner", preempt_req, 1'b1);
    lat_expired = 0; rx_req = 0; cyc();
    chk("R10", "waiter withdraws", preempt_req, 1'b0);
    chk("R4", "tx keeps bus", tx_gnt, 1'b1);
    // R11: fatal shuts the port until reset
    rx_req = 1; fatal_err = 1; cyc();
    chk("R11", "fatal tx_gnt", tx_gnt, 1'b0);
    chk("R11", "fatal preempt", preempt_req, 1'b0);
    fatal_err = 0; cyc(); cyc();
    chk("R11", "fatal sticky tx", tx_gnt, 1'b0);
    chk("R11", "fatal sticky rx", rx_gnt, 1'b0);

    // seeded random traffic under each priority setting
    for (int seg = 0; seg < 8; seg++) begin
      do_reset();
      tx_pri = seg[0]; rx_pri = seg[1];
      for (int i = 0; i < 1500; i++) begin
        tx_req      = tx_req ? ($urandom_range(99) < 90) : ($urandom_range(99) < 30);
        rx_req      = rx_req ? ($urandom_range(99) < 90) : ($urandom_range(99) < 30);
        tx_last_dw  = ($urandom_range(99) < 15);
        rx_last_dw  = ($urandom_range(99) < 15);
        lat_expired = ($urandom_range(99) < 10);
        tgt_disc    = ($urandom_range(99) < 5);
        fatal_err   = (seg == 7 && i == 1200);
        cyc();
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule